// File: doc/BRIEF.md
# Load/Store Port Handshake Controller

This block serves a single load/store request port on the memory side. An execution unit raises a load request or a store request. The controller marks the transaction as in flight with a busy flag. It then waits for the requester to mark the address valid. It answers the address with one of two single-cycle pulses: an accept pulse, given only when the access is certain to finish, or an exception pulse, given when the access can never be served. After an accept, a load returns its word with a single-cycle data-valid pulse. A store instead takes its data on a single-cycle strobe from the requester and sends back no acknowledgement.

The backing storage is a simple synchronous array of DEPTH words, each WIDTH bits wide. It has one read port with one cycle of latency and one write port. An address is in range when it is below DEPTH. The busy flag always falls on the same cycle as the pulse that ends the transaction: the exception, the load data-valid, or the first cycle after the store strobe is taken.

Top module: `lsport_ctrl`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, busy and every output pulse (address accept, address exception, load valid) are low.
- R2: When the controller is idle and exactly one of the load-request or store-request inputs is high at a clock edge, busy is high from the next cycle and stays high until the transaction ends.
- R3: After the address-valid input is sampled high in a transaction, exactly one of the accept or exception outputs is high on the next cycle, for that one cycle only.
- R4: An address greater than or equal to DEPTH draws the exception pulse, and busy is low on the same cycle as that pulse. An address below DEPTH is accepted.
- R5: A request with load-request and store-request both high is taken, and its address always draws the exception pulse, whatever the address value.
- R6: For an accepted load, the load-valid output is high for exactly one cycle, on the cycle after the accept pulse. The load data output carries the word last stored at that address, and busy is low on that same cycle.
- R7: For an accepted store, a store strobe sampled high writes the store data into the addressed word. Busy is low on the next cycle, and no accept, exception or load-valid pulse follows the strobe.
- R8: A store strobe or address-valid sampled while the controller is idle has no effect: busy stays low, no pulse is raised and the stored words are unchanged.
- R9: A load or store request raised while busy is high is ignored, and the transaction in flight completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_req_i | input | 1 | Load request |
| st_req_i | input | 1 | Store request |
| addr_vld_i | input | 1 | Address is known and valid |
| addr_i | input | AW | Word address |
| st_strobe_i | input | 1 | Store data valid strobe |
| st_data_i | input | WIDTH | Store data |
| busy_o | output | 1 | Transaction in progress |
| addr_ack_o | output | 1 | Address accepted pulse |
| addr_exc_o | output | 1 | Address exception pulse |
| ld_vld_o | output | 1 | Load data valid pulse |
| ld_data_o | output | WIDTH | Load data, valid while ld_vld_o is high |

## Verification
A state register left in the wrong phase shows at the ports within one cycle. Busy then stays high after a completion pulse, or it falls with no pulse, or an accept arrives without a load-valid on the very next cycle. A faulty range compare or request decode shows as the wrong one of the two address pulses on the cycle after address-valid. A wrong write enable or address register shows only later, when a subsequent load of that word returns data that differs from the value the bench last stored there. For that reason, every stored word is read back across the random run.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ADDR  = 2'd1,
    S_LOAD  = 2'd2,
    S_STORE = 2'd3
  } lsp_state_e;

  // An address is serviceable only when it lies below the word count.
  function automatic logic addr_in_range(input logic [31:0] addr,
                                         input int unsigned depth);
    return addr < depth;
  endfunction

endpackage

// File: rtl/lsp_range_chk.sv
module lsp_range_chk #(
  parameter int AW    = 8,
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0]    addr_i,
  output logic             in_range_o,
  output logic [IDX_W-1:0] index_o
);
  import lsp_pkg::*;

  always_comb begin
    in_range_o = addr_in_range(32'(addr_i), DEPTH);
    index_o    = addr_i[IDX_W-1:0];
  end

endmodule

// File: rtl/lsp_store.sv
module lsp_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i
);

  logic [WIDTH-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) words[wr_idx_i] <= wr_data_i;
  end

  // One cycle of read latency.
  always_ff @(posedge clk) begin
    if (rd_en_i) rd_data_o <= words[rd_idx_i];
  end

endmodule

// File: rtl/lsp_seq.sv
module lsp_seq #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_req_i,
  input  logic             st_req_i,
  input  logic             addr_vld_i,
  input  logic             addr_ok_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             st_strobe_i,
  output logic             busy_o,
  output logic             ack_o,
  output logic             exc_o,
  output logic             ld_vld_o,
  output logic             rd_en_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] idx_q_o,
  output logic             req_take_o,
  output logic             addr_take_o,
  output logic             st_take_o
);
  import lsp_pkg::*;

  lsp_state_e state_q;
  logic       is_ld_q;
  logic       bad_q;
  logic       addr_good;
  logic       addr_fail;

  always_comb begin
    req_take_o  = (state_q == S_IDLE) && (ld_req_i || st_req_i);
    addr_take_o = (state_q == S_ADDR) && addr_vld_i;
    addr_good   = addr_take_o && addr_ok_i && !bad_q;
    addr_fail   = addr_take_o && !(addr_ok_i && !bad_q);
    rd_en_o     = (state_q == S_LOAD);
    st_take_o   = (state_q == S_STORE) && st_strobe_i;
    wr_en_o     = st_take_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      busy_o   <= 1'b0;
      ack_o    <= 1'b0;
      exc_o    <= 1'b0;
      ld_vld_o <= 1'b0;
      is_ld_q  <= 1'b0;
      bad_q    <= 1'b0;
      idx_q_o  <= '0;
    end else begin
      ack_o    <= addr_good;
      exc_o    <= addr_fail;
      ld_vld_o <= rd_en_o;
      if (req_take_o) begin
        busy_o <= 1'b1;
      end else if (addr_fail || rd_en_o || st_take_o) begin
        busy_o <= 1'b0;
      end
      if (addr_take_o) idx_q_o <= idx_i;
      unique case (state_q)
        S_IDLE: begin
          if (req_take_o) begin
            is_ld_q <= ld_req_i;
            bad_q   <= ld_req_i && st_req_i;
            state_q <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (addr_fail)      state_q <= S_IDLE;
          else if (addr_good) state_q <= is_ld_q ? S_LOAD : S_STORE;
        end
        S_LOAD:  state_q <= S_IDLE;
        S_STORE: if (st_take_o) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lsport_ctrl.sv
module lsport_ctrl #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_req_i,
  input  logic             st_req_i,
  input  logic             addr_vld_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             st_strobe_i,
  input  logic [WIDTH-1:0] st_data_i,
  output logic             busy_o,
  output logic             addr_ack_o,
  output logic             addr_exc_o,
  output logic             ld_vld_o,
  output logic [WIDTH-1:0] ld_data_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             in_range;
  logic [IDX_W-1:0] idx_now;
  logic [IDX_W-1:0] idx_q;
  logic             rd_en;
  logic             wr_en;
  // Named internal events, observed by the bound checker.
  logic             req_take;
  logic             addr_take;
  logic             st_take;

  lsp_range_chk #(.AW(AW), .DEPTH(DEPTH)) u_range (
    .addr_i     (addr_i),
    .in_range_o (in_range),
    .index_o    (idx_now)
  );

  lsp_seq #(.DEPTH(DEPTH)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ld_req_i    (ld_req_i),
    .st_req_i    (st_req_i),
    .addr_vld_i  (addr_vld_i),
    .addr_ok_i   (in_range),
    .idx_i       (idx_now),
    .st_strobe_i (st_strobe_i),
    .busy_o      (busy_o),
    .ack_o       (addr_ack_o),
    .exc_o       (addr_exc_o),
    .ld_vld_o    (ld_vld_o),
    .rd_en_o     (rd_en),
    .wr_en_o     (wr_en),
    .idx_q_o     (idx_q),
    .req_take_o  (req_take),
    .addr_take_o (addr_take),
    .st_take_o   (st_take)
  );

  lsp_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rd_en_i   (rd_en),
    .rd_idx_i  (idx_q),
    .rd_data_o (ld_data_o),
    .wr_en_i   (wr_en),
    .wr_idx_i  (idx_q),
    .wr_data_i (st_data_i)
  );

endmodule

// File: rtl/lsp_chk.sv
module lsp_chk #(
  parameter int AW    = 8,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_i,
  input logic          busy_o,
  input logic          addr_ack_o,
  input logic          addr_exc_o,
  input logic          ld_vld_o,
  input logic          req_take,
  input logic          addr_take,
  input logic          st_take
);

  // R1: outputs quiet on the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !busy_o && !addr_ack_o && !addr_exc_o && !ld_vld_o);

  // R2: a taken request raises busy on the next cycle
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    req_take |=> busy_o);

  // R9: busy only rises because a request was taken in idle
  p_rise_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(req_take));

  // R3: never both answers together
  p_one_answer_r3: assert property (@(posedge clk) disable iff (rst)
    !(addr_ack_o && addr_exc_o));

  // R3: an answer follows every sampled address
  p_answer_follows_r3: assert property (@(posedge clk) disable iff (rst)
    addr_take |=> (addr_ack_o || addr_exc_o));

  // R3: answers last one cycle
  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    addr_ack_o |=> !addr_ack_o);
  p_exc_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    addr_exc_o |=> !addr_exc_o);

  // R4: exception drops busy on the same cycle
  p_exc_drop_r4: assert property (@(posedge clk) disable iff (rst)
    addr_exc_o |-> !busy_o && $past(busy_o));

  // R4: an accepted address was in range
  p_ack_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    addr_ack_o |-> (32'($past(addr_i)) < DEPTH));

  // R6: load valid follows an accept and drops busy with it
  p_ld_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
    ld_vld_o |-> $past(addr_ack_o) && !busy_o && $past(busy_o));
  p_ld_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ld_vld_o |=> !ld_vld_o);

  // R7: store strobe ends the transaction with no further pulse
  p_st_drop_r7: assert property (@(posedge clk) disable iff (rst)
    st_take |=> !busy_o && !addr_ack_o && !addr_exc_o && !ld_vld_o);

  // R8: busy only falls with a completion
  p_fall_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (addr_exc_o || ld_vld_o || $past(st_take)));

endmodule

bind lsport_ctrl lsp_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr_i     (addr_i),
  .busy_o     (busy_o),
  .addr_ack_o (addr_ack_o),
  .addr_exc_o (addr_exc_o),
  .ld_vld_o   (ld_vld_o),
  .req_take   (req_take),
  .addr_take  (addr_take),
  .st_take    (st_take)
);

// File: tb/sim_lsport_ctrl.sv
`timescale 1ns/1ps
module sim_lsport_ctrl;
  localparam int WIDTH = 32;
  localparam int DEPTH = 16;
  localparam int AW    = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             ld_req_i, st_req_i, addr_vld_i, st_strobe_i;
  logic [AW-1:0]    addr_i;
  logic [WIDTH-1:0] st_data_i;
  logic             busy_o, addr_ack_o, addr_exc_o, ld_vld_o;
  logic [WIDTH-1:0] ld_data_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [WIDTH-1:0] mdl [DEPTH];

  always #2.5 clk = ~clk;

  lsport_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
    .addr_vld_i(addr_vld_i), .addr_i(addr_i), .st_strobe_i(st_strobe_i),
    .st_data_i(st_data_i), .busy_o(busy_o), .addr_ack_o(addr_ack_o),
    .addr_exc_o(addr_exc_o), .ld_vld_o(ld_vld_o), .ld_data_o(ld_data_o)
  );

  // Expected answer: exception for out-of-range or dual-kind requests.
  function automatic bit expect_exc(input int addr, input bit both);
    return both || (addr >= DEPTH) || (addr < 0);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet_pulses(input string tag);
    chk(!addr_ack_o && !addr_exc_o && !ld_vld_o, tag,
        {addr_ack_o, addr_exc_o, ld_vld_o}, 0);
  endtask

  // Runs one transaction; called and returns at a falling edge.
  task automatic run_op(input bit is_ld, input bit both, input int addr,
                        input logic [WIDTH-1:0] d, input bit poke);
    bit bad;
    ld_req_i = is_ld || both;
    st_req_i = !is_ld || both;
    @(negedge clk);
    ld_req_i = 1'b0;
    st_req_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after request", busy_o, 1);
    if (poke) begin
      ld_req_i = 1'b1;
      st_req_i = 1'b1;
      @(negedge clk);
      ld_req_i = 1'b0;
      st_req_i = 1'b0;
      chk(busy_o == 1'b1, "R9 busy held", busy_o, 1);
      quiet_pulses("R9 no pulse on ignored request");
    end
    addr_i     = AW'(addr);
    addr_vld_i = 1'b1;
    @(negedge clk);
    addr_vld_i = 1'b0;
    bad = expect_exc(addr, both);
    chk(addr_ack_o == !bad && addr_exc_o == bad,
        both ? "R5 dual request answer" : "R3/R4 address answer",
        {addr_ack_o, addr_exc_o}, {!bad, bad});
    chk(busy_o == !bad, "R4 busy with answer", busy_o, !bad);
    if (bad) begin
      @(negedge clk);
      chk(!addr_exc_o, "R3 exception one cycle", addr_exc_o, 0);
      return;
    end
    if (is_ld) begin
      @(negedge clk);
      chk(ld_vld_o && !busy_o && !addr_ack_o, "R6 load valid and busy low",
          {ld_vld_o, busy_o, addr_ack_o}, 3'b100);
      chk(ld_data_o == mdl[addr], "R6 load data", ld_data_o, mdl[addr]);
      @(negedge clk);
      chk(!ld_vld_o, "R6 load valid one cycle", ld_vld_o, 0);
    end else begin
      @(negedge clk);
      chk(!addr_ack_o && busy_o, "R3 accept one cycle, store pending",
          {addr_ack_o, busy_o}, 2'b01);
      st_strobe_i = 1'b1;
      st_data_i   = d;
      @(negedge clk);
      st_strobe_i = 1'b0;
      mdl[addr]   = d;
      chk(!busy_o, "R7 busy low after strobe", busy_o, 0);
      quiet_pulses("R7 no acknowledgement");
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    rst = 1'b1;
    ld_req_i = 0; st_req_i = 0; addr_vld_i = 0; st_strobe_i = 0;
    addr_i = '0; st_data_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o, "R1 busy low in reset", busy_o, 0);
    quiet_pulses("R1 pulses low in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o, "R1 busy low after reset", busy_o, 0);
    quiet_pulses("R1 pulses low after reset");

    // Fill every word through the normal store path (R7).
    for (int a = 0; a < DEPTH; a++) run_op(1'b0, 1'b0, a, $urandom, 1'b0);
    for (int a = 0; a < DEPTH; a++) run_op(1'b1, 1'b0, a, '0, 1'b0);

    // Directed corners: boundary addresses, dual request (R4, R5).
    run_op(1'b1, 1'b0, DEPTH - 1, '0, 1'b0);
    run_op(1'b1, 1'b0, DEPTH, '0, 1'b0);
    run_op(1'b0, 1'b0, DEPTH, 32'hDEAD_BEEF, 1'b0);
    run_op(1'b1, 1'b0, (1 << AW) - 1, '0, 1'b0);
    run_op(1'b1, 1'b1, 2, '0, 1'b0);
    run_op(1'b1, 1'b0, 2, '0, 1'b0);

    // R9: requests raised while busy are ignored.
    run_op(1'b0, 1'b0, 5, 32'h1234_5678, 1'b1);
    run_op(1'b1, 1'b0, 5, '0, 1'b1);

    // R8: strobe and address-valid while idle are ignored.
    addr_i = AW'(5); addr_vld_i = 1'b1; st_strobe_i = 1'b1;
    st_data_i = 32'hFFFF_0000;
    @(negedge clk);
    addr_vld_i = 1'b0; st_strobe_i = 1'b0;
    chk(!busy_o, "R8 busy stays low when idle", busy_o, 0);
    quiet_pulses("R8 no pulse when idle");
    @(negedge clk);
    quiet_pulses("R8 no late pulse when idle");
    run_op(1'b1, 1'b0, 5, '0, 1'b0);

    // Random mix.
    for (int i = 0; i < 300; i++) begin
      int a;
      bit ld, both, poke;
      a    = int'($urandom_range(DEPTH + 4, 0));
      ld   = 1'($urandom_range(1, 0));
      both = ($urandom_range(15, 0) == 0);
      poke = ($urandom_range(7, 0) == 0);
      run_op(ld, both, a, $urandom, poke);
      if ($urandom_range(3, 0) == 0) @(negedge clk);
    end
    for (int a = 0; a < DEPTH; a++) run_op(1'b1, 1'b0, a, '0, 1'b0);

    summary();
    $finish;
  end

endmodule